// File: doc/BRIEF.md
# Branch Target Address Unit

This unit keeps the 16-bit instruction pointer and the 8-bit code segment pointer of a processor core, and moves them to a new place whenever the sequencer takes a jump, call or trap. The sequencer pulses a start input with a 3-bit mode code and the operand fields for that mode. The unit computes the target and loads the pointer pair. It then pulses a done strobe in the cycle where the new pair is visible at its outputs.

Five target modes exist. Four of them resolve in a single cycle: direct address, relative displacement, segment-plus-address and vector trap. The register-indirect mode takes longer. It forms a word address from a context base and a register index, then issues a read with a request/valid handshake. It loads the instruction pointer from the returned word. All address arithmetic wraps within 16 bits and never carries into the segment pointer.

Top module: `branch_target_unit`

## Requirements
- R1: While rst_n is low and after its release, ip_o = 0000h, csp_o = 00h, done_o = 0 and rd_req_o = 0 until the first operation.
- R2: A start with mode 0 (direct) loads ip_o with addr_i with bit 0 cleared, keeps csp_o, and raises done_o for one cycle on the clock edge that samples start_i.
- R3: A start with mode 1 (relative) and disp_i in 00h..7Fh sets ip_o to the old ip_o plus 2*disp_i, keeps csp_o, and completes in one cycle.
- R4: A start with mode 1 and disp_i in 80h..FFh treats disp_i as a two's-complement value d and sets ip_o to the old ip_o plus 2*(d+1), keeping csp_o.
- R5: A start with mode 2 (indirect) raises rd_req_o on the next edge, with rd_addr_o = ctx_ptr_i + 2*reg_idx_i. Both hold until rd_valid_i is sampled high, and done_o stays low meanwhile.
- R6: The edge that samples rd_valid_i high while rd_req_o is high loads ip_o with rd_data_i, drops rd_req_o, keeps csp_o and raises done_o.
- R7: A start with mode 3 (segment jump) loads csp_o with seg_i and ip_o with addr_i (bit 0 cleared) on the same edge.
- R8: A start with mode 4 (trap) loads ip_o with 4*trap_i and clears csp_o.
- R9: A start pulse while rd_req_o is high has no effect on ip_o, csp_o, rd_addr_o or done_o.
- R10: A start with mode 5, 6 or 7 changes nothing and produces no done_o.
- R11: Relative and indirect address sums wrap modulo 2^16, and csp_o is unaffected by the carry.
- R12: ip_o and csp_o change only on edges that also raise done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Take-branch pulse |
| mode_i | input | 3 | Target mode: 0 direct, 1 relative, 2 indirect, 3 segment jump, 4 trap |
| addr_i | input | 16 | Absolute code address |
| disp_i | input | 8 | Relative displacement in words |
| reg_idx_i | input | 4 | Register index for indirect mode |
| seg_i | input | 8 | Segment number |
| trap_i | input | 7 | Trap vector number |
| ctx_ptr_i | input | 16 | Context base address of the register bank |
| rd_req_o | output | 1 | Word read request, held until valid |
| rd_addr_o | output | 16 | Word read address |
| rd_valid_i | input | 1 | Read data valid |
| rd_data_i | input | 16 | Read data |
| ip_o | output | 16 | Instruction pointer |
| csp_o | output | 8 | Code segment pointer |
| done_o | output | 1 | One-cycle strobe: new pointer pair visible |

## Verification
The assertions assume that rd_valid_i is only meaningful while rd_req_o is high. They also assume that operand fields need to be stable only in the cycle that start_i is sampled, and that ctx_ptr_i and reg_idx_i are sampled with the indirect start. The stimulus drives all inputs at the falling edge and holds each operand only for its start cycle. It raises rd_valid_i only while a read is outstanding, after a random wait of zero to five cycles. During the wait, a stray start with random operands is injected to probe R9.

// File: rtl/btu_pkg.sv
package btu_pkg;
  typedef enum logic [2:0] {
    BT_DIRECT = 3'd0,
    BT_REL    = 3'd1,
    BT_IND    = 3'd2,
    BT_FAR    = 3'd3,
    BT_TRAP   = 3'd4
  } bt_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } bt_state_e;
endpackage

// File: rtl/btu_target_calc.sv
module btu_target_calc #(
  parameter int IP_W       = 16,
  parameter int SEG_W      = 8,
  parameter int DISP_W     = 8,
  parameter int IDX_W      = 4,
  parameter int TRAP_W     = 7,
  parameter int TRAP_SHIFT = 2
) (
  input  logic [2:0]        mode,
  input  logic [IP_W-1:0]   cur_ip,
  input  logic [SEG_W-1:0]  cur_csp,
  input  logic [IP_W-1:0]   addr,
  input  logic [DISP_W-1:0] disp,
  input  logic [IDX_W-1:0]  idx,
  input  logic [SEG_W-1:0]  seg,
  input  logic [TRAP_W-1:0] trap,
  input  logic [IP_W-1:0]   ctx,
  output logic [IP_W-1:0]   nxt_ip,
  output logic [SEG_W-1:0]  nxt_csp,
  output logic [IP_W-1:0]   ind_addr,
  output logic              is_direct,
  output logic              is_ind
);
  import btu_pkg::*;

  localparam int DEXT = IP_W - DISP_W;
  localparam int IEXT = IP_W - IDX_W;
  localparam int TEXT = IP_W - TRAP_W;

  logic [IP_W-1:0] disp_sx;
  logic [IP_W-1:0] rel_off;
  logic [IP_W-1:0] aligned_addr;
  logic [IP_W-1:0] trap_vec;

  always_comb begin
    disp_sx      = {{DEXT{disp[DISP_W-1]}}, disp};
    // negative displacements get one extra word before scaling
    rel_off      = (disp_sx << 1) + (disp[DISP_W-1] ? IP_W'(2) : IP_W'(0));
    aligned_addr = {addr[IP_W-1:1], 1'b0};
    trap_vec     = {{TEXT{1'b0}}, trap} << TRAP_SHIFT;
    ind_addr     = ctx + ({{IEXT{1'b0}}, idx} << 1);

    nxt_ip    = cur_ip;
    nxt_csp   = cur_csp;
    is_direct = 1'b0;
    is_ind    = 1'b0;
    case (mode)
      BT_DIRECT: begin nxt_ip = aligned_addr;    is_direct = 1'b1; end
      BT_REL:    begin nxt_ip = cur_ip + rel_off; is_direct = 1'b1; end
      BT_IND:    begin is_ind = 1'b1; end
      BT_FAR:    begin nxt_ip = aligned_addr; nxt_csp = seg; is_direct = 1'b1; end
      BT_TRAP:   begin nxt_ip = trap_vec; nxt_csp = '0; is_direct = 1'b1; end
      default:   begin end
    endcase
  end
endmodule

// File: rtl/btu_ctrl.sv
module btu_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic is_direct,
  input  logic is_ind,
  input  logic rd_valid,
  output logic load_direct,
  output logic load_ind,
  output logic launch_ind,
  output logic rd_req,
  output logic done
);
  import btu_pkg::*;

  bt_state_e state_q, state_d;
  logic      done_q, done_d;

  always_comb begin
    load_direct = (state_q == ST_IDLE) && start && is_direct;
    launch_ind  = (state_q == ST_IDLE) && start && is_ind;
    load_ind    = (state_q == ST_WAIT) && rd_valid;
    done_d      = load_direct || load_ind;
    state_d     = state_q;
    if (launch_ind)    state_d = ST_WAIT;
    else if (load_ind) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign rd_req = (state_q == ST_WAIT);
  assign done   = done_q;
endmodule

// File: rtl/btu_ptr_regs.sv
module btu_ptr_regs #(
  parameter int IP_W  = 16,
  parameter int SEG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ip_en,
  input  logic [IP_W-1:0]  ip_d,
  input  logic             csp_en,
  input  logic [SEG_W-1:0] csp_d,
  input  logic             addr_en,
  input  logic [IP_W-1:0]  addr_d,
  output logic [IP_W-1:0]  ip_q,
  output logic [SEG_W-1:0] csp_q,
  output logic [IP_W-1:0]  addr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ip_q   <= '0;
      csp_q  <= '0;
      addr_q <= '0;
    end else begin
      if (ip_en)   ip_q   <= ip_d;
      if (csp_en)  csp_q  <= csp_d;
      if (addr_en) addr_q <= addr_d;
    end
  end
endmodule

// File: rtl/branch_target_unit.sv
module branch_target_unit #(
  parameter int IP_W       = 16,
  parameter int SEG_W      = 8,
  parameter int DISP_W     = 8,
  parameter int IDX_W      = 4,
  parameter int TRAP_W     = 7,
  parameter int TRAP_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [2:0]        mode_i,
  input  logic [IP_W-1:0]   addr_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [IDX_W-1:0]  reg_idx_i,
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [TRAP_W-1:0] trap_i,
  input  logic [IP_W-1:0]   ctx_ptr_i,
  output logic              rd_req_o,
  output logic [IP_W-1:0]   rd_addr_o,
  input  logic              rd_valid_i,
  input  logic [IP_W-1:0]   rd_data_i,
  output logic [IP_W-1:0]   ip_o,
  output logic [SEG_W-1:0]  csp_o,
  output logic              done_o
);
  logic [IP_W-1:0]  nxt_ip, ind_addr, ip_d;
  logic [SEG_W-1:0] nxt_csp;
  logic             is_direct, is_ind;
  logic             load_direct, load_ind, launch_ind;

  btu_target_calc #(
    .IP_W(IP_W), .SEG_W(SEG_W), .DISP_W(DISP_W),
    .IDX_W(IDX_W), .TRAP_W(TRAP_W), .TRAP_SHIFT(TRAP_SHIFT)
  ) u_calc (
    .mode(mode_i), .cur_ip(ip_o), .cur_csp(csp_o), .addr(addr_i),
    .disp(disp_i), .idx(reg_idx_i), .seg(seg_i), .trap(trap_i),
    .ctx(ctx_ptr_i), .nxt_ip(nxt_ip), .nxt_csp(nxt_csp),
    .ind_addr(ind_addr), .is_direct(is_direct), .is_ind(is_ind)
  );

  btu_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start_i), .is_direct(is_direct),
    .is_ind(is_ind), .rd_valid(rd_valid_i), .load_direct(load_direct),
    .load_ind(load_ind), .launch_ind(launch_ind), .rd_req(rd_req_o),
    .done(done_o)
  );

  assign ip_d = load_ind ? rd_data_i : nxt_ip;

  btu_ptr_regs #(.IP_W(IP_W), .SEG_W(SEG_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .ip_en(load_direct || load_ind), .ip_d(ip_d),
    .csp_en(load_direct), .csp_d(nxt_csp),
    .addr_en(launch_ind), .addr_d(ind_addr),
    .ip_q(ip_o), .csp_q(csp_o), .addr_q(rd_addr_o)
  );
endmodule

// File: rtl/btu_checker.sv
module btu_checker #(
  parameter int IP_W       = 16,
  parameter int SEG_W      = 8,
  parameter int DISP_W     = 8,
  parameter int IDX_W      = 4,
  parameter int TRAP_W     = 7,
  parameter int TRAP_SHIFT = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [2:0]        mode_i,
  input logic [IP_W-1:0]   addr_i,
  input logic [DISP_W-1:0] disp_i,
  input logic [IDX_W-1:0]  reg_idx_i,
  input logic [SEG_W-1:0]  seg_i,
  input logic [TRAP_W-1:0] trap_i,
  input logic [IP_W-1:0]   ctx_ptr_i,
  input logic              rd_req_o,
  input logic [IP_W-1:0]   rd_addr_o,
  input logic              rd_valid_i,
  input logic [IP_W-1:0]   rd_data_i,
  input logic [IP_W-1:0]   ip_o,
  input logic [SEG_W-1:0]  csp_o,
  input logic              done_o
);
  logic idle_start;
  assign idle_start = start_i && !rd_req_o;

  a_r2_direct: assert property (@(posedge clk) disable iff (!rst_n)
    idle_start && mode_i == 3'd0 |=> done_o && ip_o == {$past(addr_i[IP_W-1:1]), 1'b0}
      && $stable(csp_o));

  a_r3_rel_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    idle_start && mode_i == 3'd1 && !disp_i[DISP_W-1] |=>
      ip_o == IP_W'($past(ip_o) + (IP_W'($past(disp_i)) << 1)));

  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o && !rd_valid_i |=> rd_req_o && $stable(rd_addr_o) && !done_o);

  a_r5_req_addr: assert property (@(posedge clk) disable iff (!rst_n)
    idle_start && mode_i == 3'd2 |=>
      rd_req_o && rd_addr_o == IP_W'($past(ctx_ptr_i) + (IP_W'($past(reg_idx_i)) << 1)));

  a_r6_ind_load: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o && rd_valid_i |=> done_o && !rd_req_o && ip_o == $past(rd_data_i)
      && $stable(csp_o));

  a_r7_far: assert property (@(posedge clk) disable iff (!rst_n)
    idle_start && mode_i == 3'd3 |=> csp_o == $past(seg_i) && ip_o[0] == 1'b0);

  a_r8_trap: assert property (@(posedge clk) disable iff (!rst_n)
    idle_start && mode_i == 3'd4 |=>
      csp_o == '0 && ip_o == (IP_W'($past(trap_i)) << TRAP_SHIFT));

  a_r10_undef: assert property (@(posedge clk) disable iff (!rst_n)
    idle_start && mode_i > 3'd4 |=> !done_o);

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(ip_o) && $stable(csp_o));
endmodule

bind branch_target_unit btu_checker #(
  .IP_W(IP_W), .SEG_W(SEG_W), .DISP_W(DISP_W),
  .IDX_W(IDX_W), .TRAP_W(TRAP_W), .TRAP_SHIFT(TRAP_SHIFT)
) u_chk (.*);

// File: tb/tb_branch_target_unit.sv
module tb_branch_target_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, rd_valid_i;
  logic [2:0]  mode_i;
  logic [15:0] addr_i, ctx_ptr_i, rd_data_i;
  logic [7:0]  disp_i, seg_i;
  logic [3:0]  reg_idx_i;
  logic [6:0]  trap_i;
  logic        rd_req_o, done_o;
  logic [15:0] rd_addr_o, ip_o;
  logic [7:0]  csp_o;

  int checks = 0, fails = 0;
  logic [15:0] m_ip;
  logic [7:0]  m_csp;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_target_unit dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] f_rel(input logic [15:0] ip, input logic [7:0] d);
    int sd;
    sd = d[7] ? int'(d) - 256 : int'(d);
    if (d[7]) return 16'(ip + 16'(2 * (sd + 1)));
    return 16'(ip + 16'(2 * sd));
  endfunction

  task automatic drive(input logic [2:0] m);
    mode_i    = m;
    addr_i    = 16'($urandom);
    disp_i    = 8'($urandom);
    reg_idx_i = 4'($urandom);
    seg_i     = 8'($urandom);
    trap_i    = 7'($urandom);
    ctx_ptr_i = 16'($urandom);
  endtask

  // single-cycle op; operand fields already set
  task automatic run_direct(input string req);
    logic [15:0] e_ip;
    logic [7:0]  e_csp;
    logic        e_done;
    e_ip = m_ip; e_csp = m_csp; e_done = 1'b1;
    case (mode_i)
      3'd0: e_ip = {addr_i[15:1], 1'b0};
      3'd1: e_ip = f_rel(m_ip, disp_i);
      3'd3: begin e_ip = {addr_i[15:1], 1'b0}; e_csp = seg_i; end
      3'd4: begin e_ip = {7'd0, trap_i, 2'b00}; e_csp = 8'h00; end
      default: e_done = 1'b0;
    endcase
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk({req, " done"}, 32'(done_o), 32'(e_done));
    chk({req, " ip"}, 32'(ip_o), 32'(e_ip));
    chk({req, " csp"}, 32'(csp_o), 32'(e_csp));
    m_ip = e_ip; m_csp = e_csp;
    @(negedge clk);
  endtask

  task automatic run_ind(input int lat, input bit stray);
    logic [15:0] e_addr, data;
    e_addr = 16'(ctx_ptr_i + {11'd0, reg_idx_i, 1'b0});
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R5 req", 32'(rd_req_o), 1);
    chk("R5 addr", 32'(rd_addr_o), 32'(e_addr));
    chk("R5 no done", 32'(done_o), 0);
    for (int i = 0; i < lat; i++) begin
      if (stray && i == 0) begin drive(3'($urandom_range(0, 4))); start_i = 1'b1; end
      @(negedge clk);
      start_i = 1'b0;
      chk("R9 ip held", 32'(ip_o), 32'(m_ip));
      chk("R9 csp held", 32'(csp_o), 32'(m_csp));
      chk("R9 addr held", 32'(rd_addr_o), 32'(e_addr));
      chk("R9 no done", 32'(done_o), 0);
    end
    data = 16'($urandom);
    rd_valid_i = 1'b1; rd_data_i = data;
    @(negedge clk);
    rd_valid_i = 1'b0; rd_data_i = 16'($urandom);
    chk("R6 done", 32'(done_o), 1);
    chk("R6 ip", 32'(ip_o), 32'(data));
    chk("R6 csp", 32'(csp_o), 32'(m_csp));
    chk("R6 req drop", 32'(rd_req_o), 0);
    m_ip = data;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; start_i = 1'b0; rd_valid_i = 1'b0; rd_data_i = '0;
    drive(3'd0);
    m_ip = '0; m_csp = '0;
    repeat (3) @(negedge clk);
    chk("R1 ip", 32'(ip_o), 0);
    chk("R1 csp", 32'(csp_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 done", 32'(done_o), 0);
    chk("R1 req", 32'(rd_req_o), 0);

    // directed corners
    drive(3'd0); addr_i = 16'hFFFF; run_direct("R2 odd addr");
    drive(3'd1); disp_i = 8'h7F;    run_direct("R3 max fwd R11 wrap");
    drive(3'd0); addr_i = 16'h0004; run_direct("R2");
    drive(3'd1); disp_i = 8'h80;    run_direct("R4 min back R11 wrap");
    drive(3'd1); disp_i = 8'hFF;    run_direct("R4 -1");
    drive(3'd1); disp_i = 8'h00;    run_direct("R3 zero");
    drive(3'd3); seg_i = 8'hFF;     run_direct("R7 far");
    drive(3'd4); trap_i = 7'h7F;    run_direct("R8 trap max");
    drive(3'd3); seg_i = 8'h5A;     run_direct("R7 far");
    drive(3'd5); run_direct("R10 mode5");
    drive(3'd7); run_direct("R10 mode7");
    drive(3'd2); ctx_ptr_i = 16'hFFF0; reg_idx_i = 4'hF; run_ind(0, 1'b0);
    drive(3'd2); run_ind(3, 1'b1);

    // random mix
    for (int n = 0; n < 400; n++) begin
      drive(3'($urandom_range(0, 7)));
      if (mode_i == 3'd2) run_ind($urandom_range(0, 5), 1'($urandom));
      else run_direct("R12 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule